// File: doc/BRIEF.md
# Banked Interrupt Line Router

This block collects the pending flags of the general-purpose pins in one bank and steers them onto a small set of bank interrupt lines. The bank holds several ports, and each port has between one and eight pins. For every pair of port and line there is a mask register, and each bit of that mask picks one pin of the port. A single pin may be steered to any subset of the lines. Each line is the OR, over all ports, of the pending flags gated by that line's mask.

Software reaches the masks, a lock register and a set of per-port status words through a simple word-addressed read/write port. The status word for a port and a line shows which of that port's pins are pending and routed to that line. The lock register has two sticky bits. Once either bit is set, the route masks can no longer be changed until the next reset. After reset every mask is zero, so no line fires until software programs the routing.

Top module: `irq_route_bank`

## Requirements
- R1: After reset every route mask reads 0, the lock register reads 0 and `irq_o` is 0.
- R2: The route mask for port p and line x is at byte address 0x14 + p*0x20 + x*4. Bit i of the mask selects pin i of port p. A write is visible on a read that follows it.
- R3: Mask bits at or above a port's pin count are stored as 0 and read back as 0. A pending bit at or above the pin count never reaches a line or a status word.
- R4: `irq_o[x]` is the OR, over all ports, of the pending bits ANDed with that port's mask for line x. It is registered, so a change on `pend_i` shows up on `irq_o` one clock later.
- R5: A pin whose bit is set in the masks of several lines raises all of those lines at once.
- R6: The status word for port p and line x is at 0x200 + p*0x20 + x*4 and reads pending AND mask for that port and line. Any read returns its data on `rdata_o` one clock after `rd_en_i`.
- R7: The lock register is at 0x0C, with the write lock at bit 28 and the read lock at bit 27. Writing a 1 to a lock bit sets it. A lock bit stays set, whatever is written later, until reset.
- R8: While either lock bit is set, writes to the route masks are ignored. Both the stored masks and the routing of `irq_o` keep their old values.
- R9: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after the read strobe |
| pend_i | input | NUM_PORTS*8 | Pending flags, 8 bits per port, pin i of port p at bit p*8+i |
| irq_o | output | NUM_LINES | Bank interrupt lines |

## Verification
The assertions assume that `pend_i` and the register strobes are synchronous to `clk` and are stable around its rising edge. On that basis they can relate the pending bits captured at one edge to the interrupt lines seen at the next. The pending bits are allowed to carry anything, including the bits above a port's pin count. The stimulus changes every input only at the falling edge and deliberately drives unused pending bits, so the property that those bits are masked is actually exercised. Lock coverage includes a reset in the middle of the run, because the lock bits can be cleared in no other way.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int          PIN_MAX     = 8;
    localparam int          ADDR_W      = 12;
    localparam int          DATA_W      = 32;

    localparam logic [11:0] LOCK_ADDR   = 12'h00C;
    localparam logic [11:0] ROUTE_BASE  = 12'h014;
    localparam int          PORT_STRIDE = 32;
    localparam logic [3:0]  STATUS_PAGE = 4'h2;

    localparam int          WLOCK_BIT   = 28;
    localparam int          RLOCK_BIT   = 27;

    // Ones across the low cnt bits; a count of 8 gives all ones.
    function automatic logic [PIN_MAX-1:0] pin_valid(input logic [3:0] cnt);
        logic [PIN_MAX:0] v;
        v = (9'd1 << cnt) - 9'd1;
        return v[PIN_MAX-1:0];
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_LINES = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              lock_hit_o,
    output logic              route_hit_o,
    output logic              status_hit_o,
    output logic [2:0]        port_o,
    output logic [2:0]        line_o
);

    localparam logic [11:0] ROUTE_SPAN = 12'(NUM_PORTS * PORT_STRIDE);

    logic [11:0] off;

    always_comb begin
        off          = addr_i - ROUTE_BASE;
        lock_hit_o   = (addr_i == LOCK_ADDR);
        route_hit_o  = (addr_i >= ROUTE_BASE) && (off < ROUTE_SPAN) &&
                       (off[1:0] == 2'b00) && (int'(off[4:2]) < NUM_LINES);
        status_hit_o = (addr_i[11:8] == STATUS_PAGE) &&
                       (int'(addr_i[7:5]) < NUM_PORTS) &&
                       (int'(addr_i[4:2]) < NUM_LINES) &&
                       (addr_i[1:0] == 2'b00);
        port_o       = route_hit_o ? off[7:5] : addr_i[7:5];
        line_o       = route_hit_o ? off[4:2] : addr_i[4:2];
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int                     NUM_PORTS  = 4,
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_PORTS*4-1:0] PIN_COUNTS = 16'h3858,
    localparam int                    NSLOT      = NUM_PORTS * NUM_LINES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic                     lock_hit_i,
    input  logic                     route_hit_i,
    input  logic [2:0]               port_i,
    input  logic [2:0]               line_i,
    input  logic [PIN_MAX-1:0]       mask_wdata_i,
    input  logic                     wlock_set_i,
    input  logic                     rlock_set_i,
    output logic [NSLOT*PIN_MAX-1:0] masks_o,
    output logic                     wlock_o,
    output logic                     rlock_o
);

    typedef struct packed {
        logic                           wlock;
        logic                           rlock;
        logic [NSLOT-1:0][PIN_MAX-1:0]  mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && lock_hit_i) begin
            st_d.wlock = st_q.wlock | wlock_set_i;
            st_d.rlock = st_q.rlock | rlock_set_i;
        end
        if (wr_en_i && route_hit_i && !st_q.wlock && !st_q.rlock) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int x = 0; x < NUM_LINES; x++) begin
                    if (port_i == 3'(p) && line_i == 3'(x)) begin
                        st_d.mask[p*NUM_LINES+x] =
                            mask_wdata_i & pin_valid(PIN_COUNTS[p*4 +: 4]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign masks_o = st_q.mask;
    assign wlock_o = st_q.wlock;
    assign rlock_o = st_q.rlock;

endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin
    import irq_route_pkg::*;
#(
    parameter int                     NUM_PORTS  = 4,
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_PORTS*4-1:0] PIN_COUNTS = 16'h3858,
    localparam int                    NSLOT      = NUM_PORTS * NUM_LINES
) (
    input  logic [NUM_PORTS*PIN_MAX-1:0] pend_i,
    input  logic [NSLOT*PIN_MAX-1:0]     masks_i,
    output logic [NSLOT*PIN_MAX-1:0]     status_o,
    output logic [NUM_LINES-1:0]         irq_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
            assign status_o[(p*NUM_LINES+x)*PIN_MAX +: PIN_MAX] =
                pend_i[p*PIN_MAX +: PIN_MAX] &
                masks_i[(p*NUM_LINES+x)*PIN_MAX +: PIN_MAX] &
                pin_valid(PIN_COUNTS[p*4 +: 4]);
        end
    end

    always_comb begin
        irq_o = '0;
        for (int x = 0; x < NUM_LINES; x++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                irq_o[x] = irq_o[x] | (|status_o[(p*NUM_LINES+x)*PIN_MAX +: PIN_MAX]);
            end
        end
    end

endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int                     NUM_PORTS  = 4,
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_PORTS*4-1:0] PIN_COUNTS = 16'h3858
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic                         rd_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    input  logic [NUM_PORTS*PIN_MAX-1:0] pend_i,
    output logic [NUM_LINES-1:0]         irq_o
);

    localparam int NSLOT = NUM_PORTS * NUM_LINES;

    typedef struct packed {
        logic [DATA_W-1:0]    rdata;
        logic [NUM_LINES-1:0] irq;
    } out_t;

    logic                     lock_hit, route_hit, status_hit;
    logic [2:0]               sel_port, sel_line;
    logic [NSLOT*PIN_MAX-1:0] route_masks, status_words;
    logic [NUM_LINES-1:0]     irq_next;
    logic                     lock_w, lock_r;
    logic                     wdata_unused;
    out_t                     out_d, out_q;

    assign wdata_unused = ^{wdata_i[31:29], wdata_i[26:8]};

    irq_route_decode #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_LINES (NUM_LINES)
    ) u_decode (
        .addr_i       (addr_i),
        .lock_hit_o   (lock_hit),
        .route_hit_o  (route_hit),
        .status_hit_o (status_hit),
        .port_o       (sel_port),
        .line_o       (sel_line)
    );

    irq_route_regs #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_LINES  (NUM_LINES),
        .PIN_COUNTS (PIN_COUNTS)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .lock_hit_i   (lock_hit),
        .route_hit_i  (route_hit),
        .port_i       (sel_port),
        .line_i       (sel_line),
        .mask_wdata_i (wdata_i[PIN_MAX-1:0]),
        .wlock_set_i  (wdata_i[WLOCK_BIT]),
        .rlock_set_i  (wdata_i[RLOCK_BIT]),
        .masks_o      (route_masks),
        .wlock_o      (lock_w),
        .rlock_o      (lock_r)
    );

    irq_route_fanin #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_LINES  (NUM_LINES),
        .PIN_COUNTS (PIN_COUNTS)
    ) u_fanin (
        .pend_i   (pend_i),
        .masks_i  (route_masks),
        .status_o (status_words),
        .irq_o    (irq_next)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = irq_next;
        if (rd_en_i) begin
            out_d.rdata = '0;
            if (lock_hit) begin
                out_d.rdata[WLOCK_BIT] = lock_w;
                out_d.rdata[RLOCK_BIT] = lock_r;
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int x = 0; x < NUM_LINES; x++) begin
                    if (sel_port == 3'(p) && sel_line == 3'(x)) begin
                        if (route_hit)
                            out_d.rdata[PIN_MAX-1:0] =
                                route_masks[(p*NUM_LINES+x)*PIN_MAX +: PIN_MAX];
                        else if (status_hit)
                            out_d.rdata[PIN_MAX-1:0] =
                                status_words[(p*NUM_LINES+x)*PIN_MAX +: PIN_MAX];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata_o = out_q.rdata;
    assign irq_o   = out_q.irq;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int                     NUM_PORTS  = 4,
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_PORTS*4-1:0] PIN_COUNTS = 16'h3858,
    localparam int                    NSLOT      = NUM_PORTS * NUM_LINES
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_PORTS*PIN_MAX-1:0] pend_i,
    input logic [NUM_LINES-1:0]         irq_o,
    input logic [NSLOT*PIN_MAX-1:0]     masks_i,
    input logic                         wlock_i,
    input logic                         rlock_i
);

    AST_WLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wlock_i |=> wlock_i); // R7

    AST_RLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rlock_i |=> rlock_i); // R7

    AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wlock_i || rlock_i) |=> $stable(masks_i)); // R8

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> $past(|pend_i)); // R4

    AST_NO_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (masks_i == '0) |=> (irq_o == '0)); // R1

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int P = s / NUM_LINES;
        AST_UNUSED_PINS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (masks_i[s*PIN_MAX +: PIN_MAX] & ~pin_valid(PIN_COUNTS[P*4 +: 4])) == '0); // R3
    end

endmodule

bind irq_route_bank irq_route_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .NUM_LINES  (NUM_LINES),
    .PIN_COUNTS (PIN_COUNTS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_i),
    .irq_o   (irq_o),
    .masks_i (route_masks),
    .wlock_i (lock_w),
    .rlock_i (lock_r)
);

// File: tb/irq_route_bank_tb.sv
`timescale 1ns/1ps
module irq_route_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pend = '0;
    logic [7:0]  irq;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    irq_route_bank u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .pend_i  (pend),
        .irq_o   (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pend = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_pend(input logic [31:0] v);
        @(negedge clk);
        pend = v;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check(irq == 8'h00, "R1 irq after reset", {24'h0, irq}, 32'h0);
        rd(12'h014, d); check(d == 32'h0, "R1 mask p0 l0 after reset", d, 32'h0);
        rd(12'h00C, d); check(d == 32'h0, "R1 lock after reset", d, 32'h0);
        drive_pend(32'hFFFF_FFFF);
        check(irq == 8'h00, "R1 no line with zero masks", {24'h0, irq}, 32'h0);
        drive_pend(32'h0);
    endtask

    task automatic t_route_write();
        logic [31:0] d;
        wr(12'h03C, 32'h0000_00FF);           // port1 (5 pins) line2
        rd(12'h03C, d); check(d == 32'h1F, "R2 R3 mask readback p1 l2", d, 32'h1F);
        wr(12'h014, 32'h0000_00A5);           // port0 (8 pins) line0
        rd(12'h014, d); check(d == 32'hA5, "R2 mask readback p0 l0", d, 32'hA5);
        wr(12'h014, 32'h0000_0001);
    endtask

    task automatic t_irq_and_status();
        logic [31:0] d;
        drive_pend(32'h0000_0800);            // port1 pin3
        check(irq == 8'h04, "R4 p1 pin3 to line2", {24'h0, irq}, 32'h04);
        rd(12'h228, d); check(d == 32'h08, "R6 status p1 l2", d, 32'h08);
        rd(12'h220, d); check(d == 32'h00, "R6 status p1 l0", d, 32'h00);
        drive_pend(32'h0000_4000);            // port1 pin6, above its pin count
        check(irq == 8'h00, "R3 unused pin ignored", {24'h0, irq}, 32'h0);
        rd(12'h228, d); check(d == 32'h00, "R3 unused pin status", d, 32'h00);
        drive_pend(32'h0);
    endtask

    task automatic t_multi_line();
        wr(12'h028, 32'h0000_0001);           // port0 line5
        drive_pend(32'h0000_0001);
        check(irq == 8'h21, "R5 pin on two lines", {24'h0, irq}, 32'h21);
        wr(12'h074, 32'h0000_0004);           // port3 line0
        drive_pend(32'h0400_0000);            // port3 pin2
        check(irq == 8'h01, "R4 port3 to line0", {24'h0, irq}, 32'h01);
        drive_pend(32'h0400_0801);
        check(irq == 8'h25, "R4 OR across ports", {24'h0, irq}, 32'h25);
        drive_pend(32'h0);
        check(irq == 8'h00, "R4 lines drop", {24'h0, irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h100, d); check(d == 32'h0, "R9 read 0x100", d, 32'h0);
        rd(12'h010, d); check(d == 32'h0, "R9 read 0x010", d, 32'h0);
    endtask

    task automatic t_read_lock();
        logic [31:0] d;
        wr(12'h00C, 32'h0800_0000);
        rd(12'h00C, d); check(d == 32'h0800_0000, "R7 read lock set", d, 32'h0800_0000);
        wr(12'h03C, 32'h0000_0000);
        rd(12'h03C, d); check(d == 32'h1F, "R8 mask kept under lock", d, 32'h1F);
        drive_pend(32'h0000_0800);
        check(irq == 8'h04, "R8 routing kept under lock", {24'h0, irq}, 32'h04);
        drive_pend(32'h0);
        wr(12'h00C, 32'h0000_0000);
        rd(12'h00C, d); check(d == 32'h0800_0000, "R7 lock sticky", d, 32'h0800_0000);
    endtask

    task automatic t_write_lock();
        logic [31:0] d;
        do_reset();
        rd(12'h00C, d); check(d == 32'h0, "R1 lock cleared by reset", d, 32'h0);
        rd(12'h03C, d); check(d == 32'h0, "R1 mask cleared by reset", d, 32'h0);
        wr(12'h00C, 32'h1000_0000);
        rd(12'h00C, d); check(d == 32'h1000_0000, "R7 write lock set", d, 32'h1000_0000);
        wr(12'h058, 32'h0000_00AA);           // port2 line1
        rd(12'h058, d); check(d == 32'h0, "R8 write ignored", d, 32'h0);
        drive_pend(32'h0002_0000);            // port2 pin1
        check(irq == 8'h00, "R8 no routing after ignored write", {24'h0, irq}, 32'h0);
        drive_pend(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_route_write();
        t_irq_and_status();
        t_multi_line();
        t_unmapped();
        t_read_lock();
        t_write_lock();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule